// File: doc/BRIEF.md
# Multi-Encoding Chromosome Mutation Unit

This block applies exactly one mutation operator to a chromosome word, picking the operator at run time from an encoding code. The chromosome is a row of `N_GENES` genes, each `GENE_W` bits wide, packed with gene 0 in the least significant bits. In bit-string mode the unit inverts a random subset of bits. In fixed-point mode it nudges chosen genes up or down by one LSB and clamps them at the field limits. In permutation mode it exchanges two genes, so an ordering stays an ordering. All three operators sit side by side and draw on one shared random word.

The random word comes from a free-running internal LFSR. When the override enable is high it comes from an input port instead, which lets a test supply every random choice. A caller raises `start` for one cycle while the unit is idle. One cycle later `done` pulses and `chrom_out` carries the result, which then holds until the next operation.

The controller has two states. `ST_IDLE` waits for work. On `start` it takes the transition *accept*, which registers the result and moves to `ST_DONE`. `ST_DONE` drives `done` and always takes the transition *retire* back to `ST_IDLE`, whatever `start` is doing.

Top module: `gene_mutator`

## Requirements
- R1: After reset `done` is 0 and `chrom_out` is all zeros.
- R2: A `start` seen in `ST_IDLE` makes `done` 1 in exactly the next cycle and 0 in the cycle after. A `start` seen while `done` is 1 is ignored and changes neither `done` nor `chrom_out`.
- R3: Mode code 0 (bit-string) gives `chrom_out = chrom_in ^ (word & FLIP_MASK)`. `word` is the random word and `FLIP_MASK` is a parameter, default 32'h1111_1111.
- R4: In mode 0, when `word & FLIP_MASK` is zero, exactly one bit is inverted: bit number `word[4:0]` (taken modulo the chromosome width).
- R5: Mode code 1 (fixed-point) steps every gene whose bit in `word[N_GENES-1:0]` is set. It adds one LSB when `word[31]` is 0 and subtracts one when `word[31]` is 1. The other genes pass through unchanged.
- R6: In mode 1 an increment of an all-ones gene and a decrement of a zero gene leave that gene unchanged (saturation).
- R7: In mode 1, when `word[N_GENES-1:0]` is zero, the only gene stepped is the one at position A = `word[10:8]`.
- R8: Mode code 2 (permutation) exchanges the genes at position A = `word[10:8]` and position B = `word[13:11]` and leaves all the other genes in place.
- R9: In mode 2, when A equals B, B is replaced by (A+1) modulo `N_GENES`, so two genes are always exchanged.
- R10: Mode code 3 copies `chrom_in` to `chrom_out` unchanged.
- R11: With `ovr_en` at 0 the random word comes from the internal LFSR. Mode 0 then always changes the chromosome, and mode 2 always yields a permutation of the input that differs from it in exactly two genes.
- R12: `chrom_out` holds its value in every cycle that does not complete an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one mutation |
| mode | input | 2 | Encoding code: 0 bit-string, 1 fixed-point, 2 permutation, 3 pass-through |
| chrom_in | input | N_GENES*GENE_W | Chromosome to mutate |
| ovr_en | input | 1 | Use `ovr_word` instead of the LFSR |
| ovr_word | input | N_GENES*GENE_W | Externally supplied random word |
| done | output | 1 | One-cycle completion pulse |
| chrom_out | output | N_GENES*GENE_W | Mutated chromosome, held between operations |

## Verification
The bench targets the points where a mutation can silently become a no-op or break its encoding. These are an empty flip mask, a gene stepped past 0 or past all-ones, an empty gene selection, and a swap of a position with itself. A design that got any of these wrong would return the input unchanged, wrap a gene to the opposite extreme, or duplicate a gene value. The bench also holds `start` high across the `done` cycle, because a controller that re-accepts there would emit a double pulse. Finally, it runs the LFSR-driven path and checks that every permutation result keeps each input value exactly once.

// File: rtl/mut_pkg.sv
package mut_pkg;
    typedef enum logic [1:0] {
        ENC_BIN  = 2'd0,
        ENC_REAL = 2'd1,
        ENC_PERM = 2'd2,
        ENC_PASS = 2'd3
    } enc_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } mut_state_t;
endpackage

// File: rtl/mut_lfsr.sv
module mut_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'hA300_0000,
    parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Right-shifting Galois register; it never reaches zero from a nonzero seed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEED;
        else if (state[0])
            state <= (state >> 1) ^ TAPS;
        else
            state <= state >> 1;
    end
endmodule

// File: rtl/mut_flip.sv
module mut_flip #(
    parameter int           CW        = 32,
    parameter logic [CW-1:0] FLIP_MASK = 32'h1111_1111
) (
    input  logic [CW-1:0] chrom,
    input  logic [CW-1:0] word,
    output logic [CW-1:0] result
);
    localparam int BIT_IDX_W = (CW > 1) ? $clog2(CW) : 1;

    logic [CW-1:0] masked;
    logic [CW-1:0] single;
    logic [31:0]   fb_idx;

    assign masked = word & FLIP_MASK;
    assign fb_idx = 32'(word[BIT_IDX_W-1:0]) % CW;

    generate
        for (genvar b = 0; b < CW; b++) begin : g_single
            assign single[b] = (fb_idx == 32'(b));
        end
    endgenerate

    assign result = chrom ^ ((masked != '0) ? masked : single);
endmodule

// File: rtl/mut_step.sv
module mut_step #(
    parameter int N     = 8,
    parameter int GW    = 4,
    parameter int IDX_W = 3
) (
    input  logic [N*GW-1:0]  chrom,
    input  logic [N-1:0]     sel,
    input  logic             dec,
    input  logic [IDX_W-1:0] pos_a,
    output logic [N*GW-1:0]  result
);
    logic [N-1:0] eff_sel;

    generate
        for (genvar g = 0; g < N; g++) begin : g_gene
            logic [GW-1:0] cur;
            logic [GW-1:0] nxt;

            assign eff_sel[g] = (sel != '0) ? sel[g] : (pos_a == IDX_W'(g));
            assign cur        = chrom[g*GW +: GW];

            always_comb begin
                nxt = cur;
                if (eff_sel[g]) begin
                    if (dec) begin
                        if (cur != '0) nxt = cur - 1'b1;
                    end else begin
                        if (cur != '1) nxt = cur + 1'b1;
                    end
                end
            end

            assign result[g*GW +: GW] = nxt;
        end
    endgenerate
endmodule

// File: rtl/mut_swap.sv
module mut_swap #(
    parameter int N     = 8,
    parameter int GW    = 4,
    parameter int IDX_W = 3
) (
    input  logic [N*GW-1:0]  chrom,
    input  logic [IDX_W-1:0] pos_a,
    input  logic [IDX_W-1:0] pos_b_raw,
    output logic [N*GW-1:0]  result
);
    logic [IDX_W-1:0] pos_b;
    logic [GW-1:0]    gene_a;
    logic [GW-1:0]    gene_b;

    always_comb begin
        if (pos_b_raw != pos_a)
            pos_b = pos_b_raw;
        else if (32'(pos_a) == N - 1)
            pos_b = '0;
        else
            pos_b = pos_a + 1'b1;
    end

    always_comb begin
        gene_a = '0;
        gene_b = '0;
        for (int i = 0; i < N; i++) begin
            if (pos_a == IDX_W'(i)) gene_a = chrom[i*GW +: GW];
            if (pos_b == IDX_W'(i)) gene_b = chrom[i*GW +: GW];
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_place
            assign result[g*GW +: GW] = (pos_a == IDX_W'(g)) ? gene_b :
                                        (pos_b == IDX_W'(g)) ? gene_a :
                                        chrom[g*GW +: GW];
        end
    endgenerate
endmodule

// File: rtl/gene_mutator.sv
module gene_mutator
    import mut_pkg::*;
#(
    parameter int N_GENES = 8,
    parameter int GENE_W  = 4,
    parameter logic [N_GENES*GENE_W-1:0] FLIP_MASK = 32'h1111_1111,
    parameter logic [N_GENES*GENE_W-1:0] LFSR_TAPS = 32'hA300_0000,
    parameter logic [N_GENES*GENE_W-1:0] LFSR_SEED = 32'h1D87_2B41
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode,
    input  logic [N_GENES*GENE_W-1:0]   chrom_in,
    input  logic                        ovr_en,
    input  logic [N_GENES*GENE_W-1:0]   ovr_word,
    output logic                        done,
    output logic [N_GENES*GENE_W-1:0]   chrom_out
);
    localparam int CW    = N_GENES * GENE_W;
    localparam int IDX_W = (N_GENES > 1) ? $clog2(N_GENES) : 1;
    localparam int POS_A = N_GENES;
    localparam int POS_B = N_GENES + IDX_W;

    initial begin
        if (CW < N_GENES + 2 * IDX_W + 1)
            $error("chromosome too narrow for random word fields");
    end

    function automatic logic [IDX_W-1:0] wrap_pos(input logic [IDX_W-1:0] raw);
        if (32'(raw) >= N_GENES)
            return raw - IDX_W'(N_GENES);
        return raw;
    endfunction

    mut_state_t state, state_nxt;

    logic [CW-1:0]    lfsr_word;
    logic [CW-1:0]    word;
    logic [IDX_W-1:0] pos_a;
    logic [IDX_W-1:0] pos_b;
    logic [CW-1:0]    res_flip;
    logic [CW-1:0]    res_step;
    logic [CW-1:0]    res_swap;
    logic [CW-1:0]    res_sel;
    logic             accept;

    mut_lfsr #(.W(CW), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_word)
    );

    assign word  = ovr_en ? ovr_word : lfsr_word;
    assign pos_a = wrap_pos(word[POS_A +: IDX_W]);
    assign pos_b = wrap_pos(word[POS_B +: IDX_W]);

    mut_flip #(.CW(CW), .FLIP_MASK(FLIP_MASK)) u_flip (
        .chrom  (chrom_in),
        .word   (word),
        .result (res_flip)
    );

    mut_step #(.N(N_GENES), .GW(GENE_W), .IDX_W(IDX_W)) u_step (
        .chrom  (chrom_in),
        .sel    (word[N_GENES-1:0]),
        .dec    (word[CW-1]),
        .pos_a  (pos_a),
        .result (res_step)
    );

    mut_swap #(.N(N_GENES), .GW(GENE_W), .IDX_W(IDX_W)) u_swap (
        .chrom     (chrom_in),
        .pos_a     (pos_a),
        .pos_b_raw (pos_b),
        .result    (res_swap)
    );

    always_comb begin
        unique case (enc_mode_t'(mode))
            ENC_BIN:  res_sel = res_flip;
            ENC_REAL: res_sel = res_step;
            ENC_PERM: res_sel = res_swap;
            ENC_PASS: res_sel = chrom_in;
        endcase
    end

    // Transitions: accept (IDLE->DONE on start), retire (DONE->IDLE always).
    assign accept = (state == ST_IDLE) && start;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chrom_out <= '0;
        else if (accept)
            chrom_out <= res_sel;
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/mut_checker.sv
module mut_checker #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    mode,
    input logic [CW-1:0] chrom_in,
    input logic          done,
    input logic [CW-1:0] chrom_out
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !done) |=> done); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !start) |=> !done); // R2

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(chrom_out) || $rose(done)); // R12

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !done && mode == 2'd3) |=> (chrom_out == $past(chrom_in))); // R10

    AST_BIN_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !done && mode == 2'd0) |=> (chrom_out != $past(chrom_in))); // R4
endmodule

bind gene_mutator mut_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .chrom_in  (chrom_in),
    .done      (done),
    .chrom_out (chrom_out)
);

// File: tb/sim_gene_mutator.sv
module sim_gene_mutator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] chrom_in = '0;
    logic        ovr_en = 1'b1;
    logic [31:0] ovr_word = '0;
    logic        done;
    logic [31:0] chrom_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    gene_mutator u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .chrom_in(chrom_in), .ovr_en(ovr_en), .ovr_word(ovr_word),
        .done(done), .chrom_out(chrom_out)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  mode;
        logic [31:0] cin;
        logic [31:0] word;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1111_1111}, // R3 full mask
        '{4'd3,  2'd0, 32'hFFFF_FFFF, 32'h0000_0010, 32'hFFFF_FFEF}, // R3 one bit
        '{4'd4,  2'd0, 32'h1234_5678, 32'h0000_0006, 32'h1234_5638}, // R4 empty mask -> bit 6
        '{4'd5,  2'd1, 32'h1234_5678, 32'h0000_0005, 32'h1234_5779}, // R5 add genes 0,2
        '{4'd5,  2'd1, 32'h1234_5678, 32'h8000_0082, 32'h0234_5668}, // R5 sub genes 1,7
        '{4'd6,  2'd1, 32'hF0F0_F0F0, 32'h0000_00FF, 32'hF1F1_F1F1}, // R6 top clamp
        '{4'd6,  2'd1, 32'hF0F0_F0F0, 32'h8000_00FF, 32'hE0E0_E0E0}, // R6 bottom clamp
        '{4'd7,  2'd1, 32'h1234_5678, 32'h0000_0300, 32'h1234_6678}, // R7 fallback gene 3
        '{4'd8,  2'd2, 32'h7654_3210, 32'h0000_3100, 32'h7154_3260}, // R8 swap 1,6
        '{4'd9,  2'd2, 32'h7654_3210, 32'h0000_3F00, 32'h0654_3217}, // R9 7,7 -> 7,0
        '{4'd10, 2'd3, 32'hDEAD_BEEF, 32'h1234_5678, 32'hDEAD_BEEF}  // R10 pass-through
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [31:0] cin, input logic [31:0] w);
        @(negedge clk);
        mode = m; chrom_in = cin; ovr_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 chrom_out", chrom_out, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].mode, VECS[i].cin, VECS[i].word);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), chrom_out, VECS[i].exp);
            chk("R2 done pulse", {31'd0, done}, 32'd1);
            @(negedge clk);
            chk("R2 done falls", {31'd0, done}, 32'd0);
        end

        // R2: start held through the done cycle is ignored there
        @(negedge clk);
        mode = 2'd3; chrom_in = 32'hAAAA_5555; start = 1'b1;
        @(negedge clk);
        chk("R2 first result", chrom_out, 32'hAAAA_5555);
        chrom_in = 32'h0F0F_0F0F;
        @(negedge clk);
        start = 1'b0;
        chk("R2 ignored start done", {31'd0, done}, 32'd0);
        chk("R2 ignored start out", chrom_out, 32'hAAAA_5555);

        // R12: output holds while idle inputs change
        held = chrom_out;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chrom_in = 32'h1357_9BDF + 32'(k); mode = 2'(k);
            chk("R12 hold", chrom_out, held);
        end

        // R11: internal random source
        ovr_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            run_op(2'd0, 32'h1234_5678, 32'h0);
            checks++;
            if (chrom_out == 32'h1234_5678) begin
                errors++;
                $display("FAIL R11 binary: actual %h expected change", chrom_out);
            end
            repeat (k + 1) @(negedge clk);
            run_op(2'd2, 32'h7654_3210, 32'h0);
            begin
                int seen [8];
                int diff;
                logic ok;
                diff = 0; ok = 1'b1;
                for (int j = 0; j < 8; j++) seen[j] = 0;
                for (int j = 0; j < 8; j++) begin
                    if (chrom_out[j*4 +: 4] > 4'd7) ok = 1'b0;
                    else seen[chrom_out[j*4 +: 3]]++;
                    if (chrom_out[j*4 +: 4] != 4'(j)) diff++;
                end
                for (int j = 0; j < 8; j++) if (seen[j] != 1) ok = 1'b0;
                if (diff != 2) ok = 1'b0;
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL R11 permutation: actual %h expected two-gene swap of 76543210", chrom_out);
                end
            end
            repeat (k + 2) @(negedge clk);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule